// File: doc/BRIEF.md
# Programmable Watchdog Down-Counter

This block is a supervisory timer for a host processor. It counts down once for each pulse of a slow tick enable, nominally 32 Hz, so one count is 31.25 ms. The count starts from a 6-bit timeout that software programs through a single control byte. Software must keep restarting the count, which it calls kicking, by writing the strobe bit. If it does not, the count reaches zero. The block then raises a sticky timeout flag and, when the interrupt enable is set, an interrupt request.

The control byte holds three fields. Bit 7 is the kick strobe. It acts only when written as 1 and always reads as 0. Bit 6 is a write-protect bit. Bits 5:0 hold the timeout. The protect bit lets software kick the timer without disturbing the programmed timeout. A timeout of zero switches the timer off. A timeout written without a kick does not act at once: it is loaded into the counter at the next tick after the write.

Top module: `watchdog_timer`

## Requirements
- R1: After reset the control byte reads back as {0, 0, RESET_TIMEOUT}, the flag and the interrupt request are low, and the counter starts from RESET_TIMEOUT, so the flag rises at the RESET_TIMEOUT-th tick.
- R2: With a non-zero timeout T loaded, the counter decrements once per cycle with tickEn high, and the flag is first seen high after the T-th tick.
- R3: A timeout of zero disables the timer: no number of ticks sets the flag.
- R4: A write with bit 7 = 1 reloads the counter from the timeout and restarts the count. A write with bit 7 = 0 that leaves the timeout unchanged does not alter the count.
- R5: Bit 7 of the readback is always 0.
- R6: Every write updates the protect bit (bit 6). Timeout bits 5:0 of a write are accepted only when the protect bit stored from the earlier writes is 0. Otherwise they are ignored, including on a kick write.
- R7: A changed timeout written without a kick takes the place of the count at the first tick after the write. It is not loaded in the write cycle, and a tick in the same cycle as the write does not load it.
- R8: The flag stays set until a flagClr pulse. After an expiry the counter holds at zero until the next kick, so further ticks do not set the flag again.
- R9: intReq is high exactly when the flag is set and intEnable is 1.
- R10: When a kick and a tick fall in the same cycle, the kick wins and the counter holds the full timeout.
- R11: When an expiry and a flagClr fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle watchdog tick, nominally 32 Hz |
| regWrEn | input | 1 | Write strobe for the control byte |
| regWrData | input | 8 | Write data: [7] kick, [6] protect, [5:0] timeout |
| flagClr | input | 1 | Pulse that clears the timeout flag, issued when the flag register is read |
| intEnable | input | 1 | Lets the flag drive the interrupt request |
| timeoutFlag | output | 1 | Sticky expiry flag |
| intReq | output | 1 | Interrupt request |
| regRdData | output | 8 | Control byte readback: [7] always 0, [6] protect, [5:0] timeout |

## Verification
The counter value is hidden, so a wrong count shows only as the flag rising at the wrong tick. The bench therefore sweeps every timeout from 1 to 63 and checks for the flag after exactly T-1 ticks and again after exactly T ticks. This finds an off-by-one or a lost reload within one expiry period. A pending load that fires too early or too late shows up as a shift of one or more ticks in the flag's arrival. A protect-bit error shows up in the readback on the cycle after the write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Per-cycle commands from the control unit to the counter datapath.
  typedef struct packed {
    logic reload;    // kick write: load the counter at once
    logic tickLoad;  // pending timeout consumed on this tick
    logic decrement; // ordinary countdown step
  } wdtCtl_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_W = 6,
  parameter int unsigned RESET_TIMEOUT = 63
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  logic                   regWrEn,
  input  logic [TIMEOUT_W+1:0]   regWrData,
  input  logic                   cntIsZero,
  output wdtCtl_t                ctl,
  output logic [TIMEOUT_W-1:0]   loadVal,
  output logic [TIMEOUT_W+1:0]   regRdData
);
  localparam int KICK_BIT = TIMEOUT_W + 1;
  localparam int PROT_BIT = TIMEOUT_W;
  localparam logic [TIMEOUT_W-1:0] TMO_RST = TIMEOUT_W'(RESET_TIMEOUT);

  logic [TIMEOUT_W-1:0] tmoQ, tmoNext, wrTmo;
  logic protQ, pendQ, pendNext;
  logic kickWr, tmoWrOk, tmoChange;

  assign wrTmo     = regWrData[TIMEOUT_W-1:0];
  assign kickWr    = regWrEn && regWrData[KICK_BIT];
  assign tmoWrOk   = regWrEn && !protQ;
  assign tmoNext   = tmoWrOk ? wrTmo : tmoQ;
  assign tmoChange = tmoWrOk && (wrTmo != tmoQ);

  // A kick clears any pending load. A fresh change arms one. A tick consumes it.
  always_comb begin
    if (kickWr)         pendNext = 1'b0;
    else if (tmoChange) pendNext = 1'b1;
    else if (tickEn)    pendNext = 1'b0;
    else                pendNext = pendQ;
  end

  always_comb begin
    ctl.reload    = kickWr;
    ctl.tickLoad  = tickEn && pendQ && !kickWr;
    ctl.decrement = tickEn && !pendQ && !kickWr && (tmoQ != '0) && !cntIsZero;
  end

  assign loadVal   = kickWr ? tmoNext : tmoQ;
  assign regRdData = {1'b0, protQ, tmoQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoQ  <= TMO_RST;
      protQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      tmoQ  <= tmoNext;
      pendQ <= pendNext;
      if (regWrEn) protQ <= regWrData[PROT_BIT];
    end
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_W = 6,
  parameter int unsigned RESET_TIMEOUT = 63
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wdtCtl_t              ctl,
  input  logic [TIMEOUT_W-1:0] loadVal,
  input  logic                 flagClr,
  input  logic                 intEnable,
  output logic                 cntIsZero,
  output logic                 timeoutFlag,
  output logic                 intReq
);
  localparam logic [TIMEOUT_W-1:0] CNT_RST = TIMEOUT_W'(RESET_TIMEOUT);

  logic [TIMEOUT_W-1:0] cntQ;
  logic flagQ, expire;

  assign cntIsZero = (cntQ == '0);
  assign expire    = ctl.decrement && (cntQ == TIMEOUT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= CNT_RST;
      flagQ <= 1'b0;
    end else begin
      if (ctl.reload || ctl.tickLoad) cntQ <= loadVal;
      else if (ctl.decrement)         cntQ <= cntQ - TIMEOUT_W'(1);
      if (expire)       flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
    end
  end

  assign timeoutFlag = flagQ;
  assign intReq      = flagQ && intEnable;
endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_W = 6,
  parameter int unsigned RESET_TIMEOUT = 63
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 regWrEn,
  input  logic [TIMEOUT_W+1:0] regWrData,
  input  logic                 flagClr,
  input  logic                 intEnable,
  output logic                 timeoutFlag,
  output logic                 intReq,
  output logic [TIMEOUT_W+1:0] regRdData
);
  wdtCtl_t ctl;
  logic [TIMEOUT_W-1:0] loadVal;
  logic cntIsZero;

  wdt_ctrl #(.TIMEOUT_W(TIMEOUT_W), .RESET_TIMEOUT(RESET_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .cntIsZero(cntIsZero), .ctl(ctl),
    .loadVal(loadVal), .regRdData(regRdData)
  );

  wdt_datapath #(.TIMEOUT_W(TIMEOUT_W), .RESET_TIMEOUT(RESET_TIMEOUT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadVal(loadVal),
    .flagClr(flagClr), .intEnable(intEnable), .cntIsZero(cntIsZero),
    .timeoutFlag(timeoutFlag), .intReq(intReq)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int TIMEOUT_W = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic                 regWrEn,
  input logic                 flagClr,
  input logic                 intEnable,
  input logic                 timeoutFlag,
  input logic                 intReq,
  input logic [TIMEOUT_W+1:0] regRdData
);
  assert_int_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !intReq);
  assert_int_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable && timeoutFlag) |-> intReq);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !flagClr) |=> timeoutFlag);
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !tickEn) |=> !timeoutFlag);
  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!timeoutFlag && !tickEn) |=> !timeoutFlag);
  assert_kick_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[TIMEOUT_W+1]);
  assert_protected_tmo_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regRdData[TIMEOUT_W]) |=> $stable(regRdData[TIMEOUT_W-1:0]));
endmodule

bind watchdog_timer wdt_checker #(.TIMEOUT_W(TIMEOUT_W)) u_wdt_checker (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
  .flagClr(flagClr), .intEnable(intEnable), .timeoutFlag(timeoutFlag),
  .intReq(intReq), .regRdData(regRdData)
);

// File: tb/test_watchdog_timer.sv
module test_watchdog_timer;
  localparam int TW = 6;
  localparam int RST_T = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic regWrEn = 1'b0;
  logic [TW+1:0] regWrData = '0;
  logic flagClr = 1'b0;
  logic intEnable = 1'b0;
  logic timeoutFlag, intReq;
  logic [TW+1:0] regRdData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  watchdog_timer #(.TIMEOUT_W(TW), .RESET_TIMEOUT(RST_T)) i_watchdog_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .flagClr(flagClr), .intEnable(intEnable),
    .timeoutFlag(timeoutFlag), .intReq(intReq), .regRdData(regRdData)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic withTick);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d; tickEn = withTick;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; tickEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic clr();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  function automatic logic [7:0] ctlByte(input logic kick, input logic prot, input int t);
    return {kick, prot, 6'(t)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 readback", 32'(regRdData), 32'(ctlByte(0, 0, RST_T)));
    check("R1 flag", 32'(timeoutFlag), 0);
    check("R1 intReq", 32'(intReq), 0);
    ticks(RST_T - 1);
    check("R1 no flag before reset timeout", 32'(timeoutFlag), 0);
    ticks(1);
    check("R1 flag at reset timeout", 32'(timeoutFlag), 1);
    // R9 interrupt gating
    check("R9 intReq disabled", 32'(intReq), 0);
    intEnable = 1'b1;
    @(negedge clk);
    check("R9 intReq enabled", 32'(intReq), 1);
    // R8 sticky and single expiry
    ticks(3);
    check("R8 flag sticky", 32'(timeoutFlag), 1);
    clr();
    check("R8 flag cleared", 32'(timeoutFlag), 0);
    check("R9 intReq follows clear", 32'(intReq), 0);
    ticks(10);
    check("R8 no second expiry without kick", 32'(timeoutFlag), 0);

    // R2 sweep over every non-zero timeout
    for (int t = 1; t < 64; t++) begin
      wr(ctlByte(1, 0, t), 1'b0);
      clr();
      check("R2 readback", 32'(regRdData), 32'(ctlByte(0, 0, t)));
      ticks(t - 1);
      check("R2 no flag at T-1", 32'(timeoutFlag), 0);
      ticks(1);
      check("R2 flag at T", 32'(timeoutFlag), 1);
    end

    // R4 kick restarts; a write without a kick and the same timeout leaves the count
    wr(ctlByte(1, 0, 6), 1'b0); clr();
    ticks(5);
    wr(ctlByte(1, 0, 6), 1'b0);
    check("R5 kick bit reads 0", 32'(regRdData[7]), 0);
    ticks(5);
    check("R4 kick restarted count", 32'(timeoutFlag), 0);
    ticks(1);
    check("R4 flag after restart", 32'(timeoutFlag), 1);
    wr(ctlByte(1, 0, 6), 1'b0); clr();
    ticks(3);
    wr(ctlByte(0, 0, 6), 1'b0);
    ticks(2);
    check("R4 zero kick bit no restart (early)", 32'(timeoutFlag), 0);
    ticks(1);
    check("R4 zero kick bit no restart", 32'(timeoutFlag), 1);

    // R6 protect bit
    wr(ctlByte(0, 1, 9), 1'b0);
    check("R6 write arms protect", 32'(regRdData), 32'(ctlByte(0, 1, 9)));
    wr(ctlByte(0, 1, 2), 1'b0);
    check("R6 timeout ignored", 32'(regRdData), 32'(ctlByte(0, 1, 9)));
    wr(ctlByte(0, 0, 3), 1'b0);
    check("R6 unprotect write ignores timeout", 32'(regRdData), 32'(ctlByte(0, 0, 9)));
    wr(ctlByte(0, 0, 3), 1'b0);
    check("R6 timeout accepted", 32'(regRdData), 32'(ctlByte(0, 0, 3)));
    wr(ctlByte(0, 1, 7), 1'b0);
    wr(ctlByte(1, 1, 20), 1'b0); clr();
    check("R6 kick under protect keeps timeout", 32'(regRdData), 32'(ctlByte(0, 1, 7)));
    ticks(6);
    check("R6 reload used stored timeout (early)", 32'(timeoutFlag), 0);
    ticks(1);
    check("R6 reload used stored timeout", 32'(timeoutFlag), 1);
    wr(ctlByte(0, 0, 7), 1'b0);

    // R7 deferred load of a new timeout
    wr(ctlByte(1, 0, 10), 1'b0); clr();
    ticks(2);
    wr(ctlByte(0, 0, 3), 1'b1);
    ticks(3);
    check("R7 new timeout not yet expired", 32'(timeoutFlag), 0);
    ticks(1);
    check("R7 new timeout loaded on next tick", 32'(timeoutFlag), 1);

    // R10 kick and tick together
    wr(ctlByte(1, 0, 4), 1'b0); clr();
    ticks(2);
    wr(ctlByte(1, 0, 4), 1'b1);
    ticks(3);
    check("R10 kick wins over tick (early)", 32'(timeoutFlag), 0);
    ticks(1);
    check("R10 kick wins over tick", 32'(timeoutFlag), 1);

    // R11 expiry and clear together
    wr(ctlByte(1, 0, 2), 1'b0); clr();
    ticks(1);
    @(negedge clk); tickEn = 1'b1; flagClr = 1'b1;
    @(negedge clk); tickEn = 1'b0; flagClr = 1'b0;
    check("R11 set beats clear", 32'(timeoutFlag), 1);

    // R3 zero timeout disables
    wr(ctlByte(1, 0, 0), 1'b0); clr();
    ticks(70);
    check("R3 zero timeout never expires", 32'(timeoutFlag), 0);
    check("R3 intReq stays low", 32'(intReq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule